// File: doc/BRIEF.md
# Lockable Seconds Watchdog

This block is a watchdog timer with one 32-bit control and status word on a simple register bus. Software picks a period in whole seconds, turns the timer on, and keeps it alive by writing a restart command before the period runs out. A once-only freeze bit locks the period, the run bit and the freeze bit itself until the next power-on reset. Restart commands are still accepted while frozen, so a locked watchdog can still be serviced.

The countdown advances on a one-clock-wide tick input that pulses once per second. When the countdown runs out, the block drives a reset request for a fixed number of clocks. It also sets one of two sticky cause flags, chosen by a survivability-mode input. The flags survive the reset request and clear only on power-on reset or when software writes a 1 to them. A newly written period is held pending and takes effect on the next restart. Turning the timer on from the off state always starts a fresh count from the committed period.

Top module: `sec_watchdog`

## Requirements
- R1: After power-on reset the word reads 0x0000003B: period field 59 (a 60 s period), run bit 0, freeze bit 0, both cause flags 0. The reset request is low.
- R2: Bits 9:0 hold the period field P. While running, the reset request rises on the (P+1)th tick after the count was loaded, and no earlier.
- R3: Bit 14 is the run bit. Writing it from 0 to 1 loads the count from the committed period. Writing it to 0 stops the count, so no ticks lead to expiry while it is 0.
- R4: Writing 1 to bit 31 restarts the count from the full committed period. This happens even while frozen. Bit 31 always reads 0.
- R5: A period written without bit 31 does not change the running count. The old period stays in force until a restart commits the new one. A restart write that carries a new period commits that value.
- R6: Writing 1 to bit 12 sets the freeze bit. After that, writes leave the period field, the run bit and the freeze bit unchanged until power-on reset.
- R7: A read at the block address returns the word on the clock after the read strobe, and 0 at any other time. Writes and reads at other addresses have no effect and return 0.
- R8: Each expiry drives the reset request high for exactly PULSE_CYC clocks (4 by default).
- R9: An expiry sets bit 25 if the survivability input is high, else bit 24. The flags stay set through the reset request, clear on power-on reset, and clear when a 1 is written to them.
- R10: After an expiry the count reloads from the committed period and keeps running. Another expiry follows after P+1 more ticks.
- R11: A restart in the same clock as the final tick wins: no expiry occurs, and a full period begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low; clears everything including freeze and flags |
| tick | input | 1 | One-clock pulse, once per second |
| surv_mode | input | 1 | Survivability mode; selects which cause flag an expiry sets |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered; 0 when no read |
| rst_req | output | 1 | Reset request to the system |

## Verification
A write takes effect at the clock edge on which its strobe is sampled. Read data appears one edge after the read strobe, so the bench drives on falling edges and samples read data at the next falling edge. An expiry is decided at the edge that samples the final tick. The reset request is high from that edge on, so it is checked at the falling edge right after the tick, and its length is counted over the following falling edges. The freeze and restart checks read the word back between writes, so every ignored write is observed at the port before the next stimulus.

// File: rtl/sec_watchdog_pkg.sv
package sec_watchdog_pkg;

   localparam int WORD_W   = 32;
   localparam int FRZ_BIT  = 12;
   localparam int RUN_BIT  = 14;
   localparam int CAUSE_LO = 24;   // plain expiry flag; survivability flag sits one above
   localparam int RST_BIT  = 31;
   localparam int N_CAUSE  = 2;

   typedef struct packed {
      logic restart;   // restart command accepted this clock
      logic run_up;    // run bit going 0 -> 1 this clock
   } wd_cmd_t;

endpackage

// File: rtl/sec_watchdog_regs.sv
module sec_watchdog_regs
   import sec_watchdog_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int REG_ADDR = 0,
   parameter int TOV_W    = 10,
   parameter int DEF_TOV  = 60
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WORD_W-1:0] bus_wdata,
   input  logic              expire,
   input  logic              surv_mode,
   output logic [TOV_W-1:0]  tov_pend,
   output logic [TOV_W-1:0]  tov_next,
   output logic              run_q,
   output logic              frz_q,
   output logic [N_CAUSE-1:0] cause_q,
   output wd_cmd_t           cmd,
   output logic              wr_hit,
   output logic [WORD_W-1:0] bus_rdata
);

   localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);
   localparam logic [TOV_W-1:0]  TOV_RST  = TOV_W'(DEF_TOV - 1);

   logic rd_hit;
   logic cfg_wr;
   logic unused_wdata;
   logic [WORD_W-1:0] view;

   assign wr_hit = bus_wr && (bus_addr == HIT_ADDR);
   assign rd_hit = bus_rd && (bus_addr == HIT_ADDR);
   assign cfg_wr = wr_hit && !frz_q;
   assign unused_wdata = ^bus_wdata;

   // value committed by a restart in this clock: fresh write data wins over pending
   assign tov_next = cfg_wr ? bus_wdata[TOV_W-1:0] : tov_pend;

   assign cmd.restart = wr_hit && bus_wdata[RST_BIT];
   assign cmd.run_up  = cfg_wr && bus_wdata[RUN_BIT] && !run_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         tov_pend <= TOV_RST;
         run_q    <= 1'b0;
         frz_q    <= 1'b0;
      end else if (cfg_wr) begin
         tov_pend <= bus_wdata[TOV_W-1:0];
         run_q    <= bus_wdata[RUN_BIT];
         frz_q    <= bus_wdata[FRZ_BIT];
      end
   end

   for (genvar b = 0; b < N_CAUSE; b++) begin : g_cause
      logic set_b;
      assign set_b = expire && (surv_mode == (b == 1));
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)
            cause_q[b] <= 1'b0;
         else if (set_b)
            cause_q[b] <= 1'b1;
         else if (wr_hit && bus_wdata[CAUSE_LO+b])
            cause_q[b] <= 1'b0;
      end
   end

   always_comb begin
      view = '0;
      view[TOV_W-1:0] = tov_pend;
      view[FRZ_BIT]   = frz_q;
      view[RUN_BIT]   = run_q;
      view[CAUSE_LO +: N_CAUSE] = cause_q;
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         bus_rdata <= '0;
      else
         bus_rdata <= rd_hit ? view : '0;
   end

endmodule

// File: rtl/sec_watchdog_count.sv
module sec_watchdog_count
   import sec_watchdog_pkg::*;
#(
   parameter int TOV_W   = 10,
   parameter int DEF_TOV = 60
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             tick,
   input  logic             run_q,
   input  wd_cmd_t          cmd,
   input  logic [TOV_W-1:0] tov_next,
   output logic             expire
);

   localparam logic [TOV_W-1:0] TOV_RST = TOV_W'(DEF_TOV - 1);

   logic [TOV_W-1:0] tov_cur;
   logic [TOV_W-1:0] cnt_q;
   logic             step;

   assign step   = tick && run_q;
   assign expire = step && (cnt_q == '0) && !cmd.restart;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         tov_cur <= TOV_RST;
         cnt_q   <= TOV_RST;
      end else if (cmd.restart) begin
         tov_cur <= tov_next;
         cnt_q   <= tov_next;
      end else if (cmd.run_up) begin
         cnt_q   <= tov_cur;
      end else if (expire) begin
         cnt_q   <= tov_cur;
      end else if (step) begin
         cnt_q   <= cnt_q - 1'b1;
      end
   end

endmodule

// File: rtl/sec_watchdog_pulse.sv
module sec_watchdog_pulse #(
   parameter int PULSE_CYC = 4
) (
   input  logic clk,
   input  logic por_n,
   input  logic expire,
   output logic rst_req
);

   if (PULSE_CYC == 1) begin : g_single
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n) rst_req <= 1'b0;
         else        rst_req <= expire;
      end
   end else begin : g_stretch
      localparam int CW = $clog2(PULSE_CYC + 1);
      logic [CW-1:0] left_q;
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)             left_q <= '0;
         else if (expire)        left_q <= CW'(PULSE_CYC);
         else if (left_q != '0)  left_q <= left_q - 1'b1;
      end
      assign rst_req = (left_q != '0);
   end

endmodule

// File: rtl/sec_watchdog.sv
module sec_watchdog
   import sec_watchdog_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int REG_ADDR  = 0,
   parameter int TOV_W     = 10,
   parameter int DEF_TOV   = 60,
   parameter int PULSE_CYC = 4
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              tick,
   input  logic              surv_mode,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              rst_req
);

   initial begin
      assert (TOV_W >= 1 && TOV_W <= FRZ_BIT) else $fatal(1, "TOV_W out of range");
      assert (DEF_TOV >= 1 && DEF_TOV <= (1 << TOV_W)) else $fatal(1, "DEF_TOV out of range");
      assert (PULSE_CYC >= 1 && PULSE_CYC <= 255) else $fatal(1, "PULSE_CYC out of range");
      assert (REG_ADDR >= 0 && REG_ADDR < (1 << ADDR_W)) else $fatal(1, "REG_ADDR out of range");
   end

   logic [TOV_W-1:0]   tov_pend;
   logic [TOV_W-1:0]   tov_next;
   logic               run_q;
   logic               frz_q;
   logic [N_CAUSE-1:0] cause_q;
   logic               wr_hit;
   logic               expire;
   wd_cmd_t            cmd;

   sec_watchdog_regs #(
      .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .TOV_W(TOV_W), .DEF_TOV(DEF_TOV)
   ) u_regs (
      .clk(clk), .por_n(por_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .expire(expire),
      .surv_mode(surv_mode), .tov_pend(tov_pend), .tov_next(tov_next),
      .run_q(run_q), .frz_q(frz_q), .cause_q(cause_q), .cmd(cmd),
      .wr_hit(wr_hit), .bus_rdata(bus_rdata)
   );

   sec_watchdog_count #(
      .TOV_W(TOV_W), .DEF_TOV(DEF_TOV)
   ) u_count (
      .clk(clk), .por_n(por_n), .tick(tick), .run_q(run_q), .cmd(cmd),
      .tov_next(tov_next), .expire(expire)
   );

   sec_watchdog_pulse #(
      .PULSE_CYC(PULSE_CYC)
   ) u_pulse (
      .clk(clk), .por_n(por_n), .expire(expire), .rst_req(rst_req)
   );

endmodule

// File: rtl/sec_watchdog_chk.sv
module sec_watchdog_chk #(
   parameter int TOV_W     = 10,
   parameter int PULSE_CYC = 4
) (
   input logic             clk,
   input logic             por_n,
   input logic             run_q,
   input logic             frz_q,
   input logic [TOV_W-1:0] tov_pend,
   input logic [1:0]       cause_q,
   input logic             wr_hit,
   input logic [31:0]      bus_wdata,
   input logic             expire,
   input logic             rst_req,
   input logic [31:0]      bus_rdata
);

   logic [8:0] run_len;
   logic       unused_chk;
   assign unused_chk = ^bus_wdata[23:0] ^ ^bus_wdata[31:26];

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)       run_len <= '0;
      else if (rst_req) run_len <= run_len + 1'b1;
      else              run_len <= '0;
   end

   p_freeze_holds_r6: assert property (@(posedge clk) disable iff (!por_n)
      frz_q |=> frz_q);

   p_frozen_cfg_stable_r6: assert property (@(posedge clk) disable iff (!por_n)
      frz_q |=> ($stable(run_q) && $stable(tov_pend)));

   p_stopped_no_expiry_r3: assert property (@(posedge clk) disable iff (!por_n)
      !run_q |-> !expire);

   p_expiry_requests_r8: assert property (@(posedge clk) disable iff (!por_n)
      expire |=> rst_req);

   p_pulse_length_r8: assert property (@(posedge clk) disable iff (!por_n)
      $fell(rst_req) |-> (run_len == 9'(PULSE_CYC)));

   p_expiry_flags_r9: assert property (@(posedge clk) disable iff (!por_n)
      expire |=> (cause_q != 2'b00));

   p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!por_n)
      (cause_q[0] && !(wr_hit && bus_wdata[24])) |=> cause_q[0]);

   p_restart_reads_zero_r4: assert property (@(posedge clk) disable iff (!por_n)
      $past(wr_hit) |-> !bus_rdata[31]);

endmodule

bind sec_watchdog sec_watchdog_chk #(.TOV_W(TOV_W), .PULSE_CYC(PULSE_CYC)) u_chk (
   .clk(clk), .por_n(por_n), .run_q(run_q), .frz_q(frz_q), .tov_pend(tov_pend),
   .cause_q(cause_q), .wr_hit(wr_hit), .bus_wdata(bus_wdata), .expire(expire),
   .rst_req(rst_req), .bus_rdata(bus_rdata)
);

// File: tb/sec_watchdog_test.sv
`timescale 1ns/1ps
module sec_watchdog_test;

   localparam int PULSE = 4;
   localparam logic [3:0]  RA   = 4'd0;
   localparam logic [31:0] RUN  = 32'h0000_4000;
   localparam logic [31:0] FRZ  = 32'h0000_1000;
   localparam logic [31:0] RST  = 32'h8000_0000;
   localparam logic [31:0] FLGS = 32'h0300_0000;

   typedef struct packed {
      logic [9:0]  tov;
      logic        surv;
      logic [10:0] ticks;
      logic [1:0]  flags;
   } vec_t;

   localparam vec_t VT [4] = '{
      '{tov: 10'd0,  surv: 1'b0, ticks: 11'd1,  flags: 2'b01},
      '{tov: 10'd1,  surv: 1'b1, ticks: 11'd2,  flags: 2'b10},
      '{tov: 10'd5,  surv: 1'b0, ticks: 11'd6,  flags: 2'b01},
      '{tov: 10'd12, surv: 1'b1, ticks: 11'd13, flags: 2'b10}
   };

   logic        clk = 0;
   logic        por_n = 0;
   logic        tick = 0;
   logic        surv_mode = 0;
   logic        bus_wr = 0;
   logic        bus_rd = 0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        rst_req;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   sec_watchdog uut (
      .clk(clk), .por_n(por_n), .tick(tick), .surv_mode(surv_mode),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 0; bus_wdata = '0; bus_addr = RA;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1; bus_addr = a;
      @(negedge clk);
      bus_rd = 0; bus_addr = RA;
      d = bus_rdata;
   endtask

   task automatic pulse_tick();
      @(negedge clk);
      tick = 1;
      @(negedge clk);
      tick = 0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) pulse_tick();
   endtask

   task automatic pulse_len(output int n);
      n = 0;
      while (rst_req && n < 100) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic do_por();
      @(negedge clk);
      por_n = 0;
      repeat (3) @(negedge clk);
      por_n = 1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual hung expected finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      int n;
      repeat (4) @(negedge clk);
      por_n = 1;

      // R1: reset state
      check("R1 rst_req", {31'd0, rst_req}, 32'd0);
      rd(RA, r);
      check("R1 reset word", r, 32'h0000_003B);
      // R7: read data returns to zero after the read clock
      @(negedge clk);
      check("R7 idle rdata", bus_rdata, 32'd0);

      // table: R2 period, R8 pulse, R9 cause flag
      for (int v = 0; v < 4; v++) begin
         wr(RA, 32'(VT[v].tov) | RST);
         wr(RA, 32'(VT[v].tov) | RUN);
         surv_mode = VT[v].surv;
         ticks(int'(VT[v].ticks) - 1);
         check("R2 no early expiry", {31'd0, rst_req}, 32'd0);
         pulse_tick();
         check("R2 expiry at P+1", {31'd0, rst_req}, 32'd1);
         pulse_len(n);
         check("R8 pulse length", 32'(n), 32'(PULSE));
         rd(RA, r);
         check("R9 cause flag", {30'd0, r[25:24]}, {30'd0, VT[v].flags});
         check("R4 restart bit reads 0", {31'd0, r[31]}, 32'd0);
         check("R7 period readback", {22'd0, r[9:0]}, {22'd0, VT[v].tov});
         wr(RA, 32'(VT[v].tov) | FLGS);
         rd(RA, r);
         check("R9 W1C clears flags", {30'd0, r[25:24]}, 32'd0);
      end
      surv_mode = 0;

      // R5: pending period has no effect until restart; R10: rerun after expiry
      wr(RA, 32'd3 | RST);
      wr(RA, 32'd3 | RUN);
      wr(RA, 32'd9 | RUN);
      ticks(3);
      check("R5 old period no early", {31'd0, rst_req}, 32'd0);
      pulse_tick();
      check("R5 old period in force", {31'd0, rst_req}, 32'd1);
      pulse_len(n);
      ticks(3);
      check("R10 no early rerun", {31'd0, rst_req}, 32'd0);
      pulse_tick();
      check("R10 second expiry", {31'd0, rst_req}, 32'd1);
      pulse_len(n);
      wr(RA, 32'd9 | RUN | RST);
      ticks(9);
      check("R4 restart commits new period", {31'd0, rst_req}, 32'd0);
      pulse_tick();
      check("R4 new period expiry", {31'd0, rst_req}, 32'd1);
      pulse_len(n);
      wr(RA, FLGS);

      // R3: stop halts count, start loads a fresh count
      wr(RA, 32'd2 | RST);
      wr(RA, 32'd2 | RUN);
      ticks(2);
      wr(RA, 32'd2);
      ticks(5);
      check("R3 stopped no expiry", {31'd0, rst_req}, 32'd0);
      wr(RA, 32'd2 | RUN);
      ticks(2);
      check("R3 fresh count not resumed", {31'd0, rst_req}, 32'd0);
      pulse_tick();
      check("R3 fresh count expiry", {31'd0, rst_req}, 32'd1);
      pulse_len(n);
      wr(RA, 32'd2 | FLGS);

      // R11: restart in the same clock as the final tick
      wr(RA, 32'd1 | RST);
      wr(RA, 32'd1 | RUN);
      pulse_tick();
      @(negedge clk);
      bus_wr = 1; bus_addr = RA; bus_wdata = 32'd1 | RUN | RST; tick = 1;
      @(negedge clk);
      bus_wr = 0; bus_wdata = '0; tick = 0;
      check("R11 restart beats final tick", {31'd0, rst_req}, 32'd0);
      pulse_tick();
      check("R11 full period after", {31'd0, rst_req}, 32'd0);
      pulse_tick();
      check("R11 expiry after full period", {31'd0, rst_req}, 32'd1);
      pulse_len(n);
      wr(RA, 32'd1 | FLGS);

      // R7: other addresses ignored
      wr(4'd1, 32'h0000_43FF);
      rd(RA, r);
      check("R7 stray write ignored", r, 32'h0000_0001);
      rd(4'd1, r);
      check("R7 stray read zero", r, 32'd0);

      // R6: freeze; R4 restart under freeze; R9 flags survive request
      wr(RA, 32'd4 | RUN | FRZ | RST);
      rd(RA, r);
      check("R6 frozen word", r, 32'h0000_5004);
      wr(RA, 32'd0);
      rd(RA, r);
      check("R6 write ignored when frozen", r, 32'h0000_5004);
      ticks(3);
      wr(RA, RST);
      ticks(4);
      check("R4 restart honoured when frozen", {31'd0, rst_req}, 32'd0);
      pulse_tick();
      check("R4 frozen expiry", {31'd0, rst_req}, 32'd1);
      pulse_len(n);
      rd(RA, r);
      check("R9 flag kept through request", r, 32'h0100_5004);
      do_por();
      rd(RA, r);
      check("R6 power-on unfreezes R9 clears", r, 32'h0000_003B);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule